// File: doc/BRIEF.md
# Phase Comparator with Lock-Loss Monitor

This block compares two streams of single-cycle edge strobes, one from the reference divider and one from the divided-down oscillator, and turns their timing difference into pump drive requests. The main pump is asked to drive high while a feedback edge is waiting for its reference partner, and to drive low while a reference edge is waiting for its feedback partner. When neither edge is pending, both drive requests are off and the pump is high-impedance. Each pump is modelled as a pair of enables: a drive-high request and a drive-low request. When both are zero the pump is high-impedance.

The same error window feeds a lock-loss monitor. Software picks one of four monitor settings. With the first, the monitor is off. With the second, the raw error pulse is passed through. The other two compare the error width against a narrow or a wide cycle threshold and hold the indication for a millisecond-scale stretch after the last offending cycle. The unlock output is modelled as an active-low open-drain request: `unlock_low` = 1 means the pin is pulled low. An auxiliary pump follows the main pump's direction. It can be disabled, run all the time, or run only while the loop is judged unlocked.

A force input parks every pump in its drive-low state, for use in clearing a stalled loop. The enable input has priority over the force input: with the enable low, all pump drives are off and all monitor state is cleared.

Top module: `pfd_lock_monitor`

## Requirements
- R1: After a synchronous reset, every pump drive request and `unlock_low` are 0. No pump ever requests drive-high and drive-low at the same time, except as allowed by the force of R4.
- R2: If a feedback strobe leads the matching reference strobe by W cycles, `pump_hi` is 1 for exactly W cycles and `pump_lo` stays 0. If the reference leads by W, `pump_lo` is 1 for W cycles and `pump_hi` stays 0. Strobes in the same cycle produce no drive. The output trails the leading strobe by one register stage.
- R3: While `pll_en` is 0, all four pump requests and `unlock_low` are 0 from the next cycle on, even while `force_low` is 1.
- R4: While `pll_en` is 1 and `force_low` is 1, `pump_lo` and `aux_lo` are 1 and `pump_hi` and `aux_hi` are 0 from the next cycle on, whatever the sub-pump settings.
- R5: With `unl_sel` = 2'b00, `unlock_low` stays 0 for any phase error.
- R6: With `unl_sel` = 2'b01, `unlock_low` is 1 for exactly as many cycles as the main pump drives for each error pulse.
- R7: With `unl_sel` = 2'b10 (threshold THR_NARROW) or 2'b11 (threshold THR_WIDE), an error pulse of W cycles sets `unlock_low` when W > threshold, and does not set it when W <= threshold.
- R8: In the threshold settings, `unlock_low` stays 1 after the last over-threshold cycle until STRETCH_TICKS `ms_tick` strobes have been seen. Each new over-threshold cycle reloads the stretch.
- R9: With `sub_en` = 0 and no force, `aux_hi` and `aux_lo` stay 0.
- R10: With `sub_en` = 1 and `sub_always` = 1, the auxiliary pump repeats the main pump's drive cycle for cycle.
- R11: With `sub_en` = 1 and `sub_always` = 0, in a threshold setting, the auxiliary pump runs from the first over-threshold cycle of an error pulse (W minus threshold cycles for a fresh W > threshold). It keeps running on following pulses until one pulse completes within the threshold; it runs for that pulse, then goes idle. In setting 2'b01 it runs whenever an error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_en | input | 1 | 1 = loop running; 0 = inhibited, all pumps off |
| ref_edge | input | 1 | One-cycle strobe per reference edge |
| fb_edge | input | 1 | One-cycle strobe per divided-feedback edge |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| unl_sel | input | 2 | Monitor setting: 00 off, 01 raw, 10 narrow, 11 wide |
| sub_en | input | 1 | Auxiliary pump enable |
| sub_always | input | 1 | 1 = auxiliary pump runs continuously, 0 = only while unlocked |
| force_low | input | 1 | Force all pumps to drive low |
| pump_hi | output | 1 | Main pump drive-high request |
| pump_lo | output | 1 | Main pump drive-low request |
| aux_hi | output | 1 | Auxiliary pump drive-high request |
| aux_lo | output | 1 | Auxiliary pump drive-low request |
| unlock_low | output | 1 | 1 = unlock pin pulled low (unlocked) |

## Verification
The bench sweeps the error width across both sides of each threshold, in both lead directions, and counts drive cycles. An off-by-one in the comparison, or in the pipeline, shows up as a count that is one too high or one too low, or as a flag that fires at exactly the threshold. It checks that the auxiliary pump keeps running across one in-threshold pulse and then drops out. A design that cleared its unlocked state too early or too late would show auxiliary drive on the wrong pulse. It counts millisecond ticks across the stretch expiry, and checks that enable has priority over force. An inverted priority or a stretch that ignores ticks would show a pin left in the wrong state.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;
  typedef enum logic [1:0] {
    UNL_OFF    = 2'b00,
    UNL_RAW    = 2'b01,
    UNL_NARROW = 2'b10,
    UNL_WIDE   = 2'b11
  } unl_sel_e;

  localparam int PUMP_MAIN  = 0;
  localparam int PUMP_AUX   = 1;
  localparam int PUMP_COUNT = 2;
endpackage

// File: rtl/pfd_edge_core.sv
module pfd_edge_core #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ref_edge,
  input  logic             fb_edge,
  output logic             lead_fb,
  output logic             lead_ref,
  output logic             active,
  output logic             pulse_end,
  output logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic nxt_fb, nxt_ref, nxt_active;

  always_comb begin
    nxt_fb  = lead_fb  | fb_edge;
    nxt_ref = lead_ref | ref_edge;
    if (nxt_fb && nxt_ref) begin
      nxt_fb  = 1'b0;
      nxt_ref = 1'b0;
    end
    if (!en) begin
      nxt_fb  = 1'b0;
      nxt_ref = 1'b0;
    end
    nxt_active = nxt_fb | nxt_ref;
  end

  assign active    = lead_fb | lead_ref;
  assign pulse_end = active & ~nxt_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      lead_fb  <= 1'b0;
      lead_ref <= 1'b0;
      err_cnt  <= '0;
    end else begin
      lead_fb  <= nxt_fb;
      lead_ref <= nxt_ref;
      if (!nxt_active)
        err_cnt <= '0;
      else if (err_cnt != CNT_MAX)
        err_cnt <= err_cnt + 1'b1;
    end
  end

  // R2: one side may lead at a time
  a_r2_single_lead: assert property (@(posedge clk) disable iff (rst)
    !(lead_fb && lead_ref));

  // R2: counter restarts from one on a fresh error
  a_r2_fresh_count: assert property (@(posedge clk) disable iff (rst)
    (!active && (lead_fb || lead_ref || fb_edge || ref_edge) && en && !(fb_edge && ref_edge))
      |=> (err_cnt == 1));

  // R3: no pending edge survives inhibit
  a_r3_idle_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !active);
endmodule

// File: rtl/pfd_unlock_mon.sv
module pfd_unlock_mon
  import pfd_lock_pkg::*;
#(
  parameter int THR_NARROW    = 140,
  parameter int THR_WIDE      = 278,
  parameter int CNT_W         = 9,
  parameter int STRETCH_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       sel,
  input  logic             active,
  input  logic             pulse_end,
  input  logic [CNT_W-1:0] err_cnt,
  input  logic             ms_tick,
  output logic             unlock_low,
  output logic             sub_unl
);
  localparam int SW = (STRETCH_TICKS < 2) ? 1 : $clog2(STRETCH_TICKS + 1);
  localparam logic [SW-1:0]    STRETCH_LOAD = SW'(STRETCH_TICKS);
  localparam logic [CNT_W-1:0] THR_N = CNT_W'(THR_NARROW);
  localparam logic [CNT_W-1:0] THR_W = CNT_W'(THR_WIDE);

  unl_sel_e         mode;
  logic [CNT_W-1:0] thr;
  logic             thr_mode;
  logic             over;
  logic             unl_now;
  logic [SW-1:0]    stretch;

  assign mode     = unl_sel_e'(sel);
  assign thr_mode = (mode == UNL_NARROW) || (mode == UNL_WIDE);

  always_comb begin
    case (mode)
      UNL_WIDE: thr = THR_W;
      default:  thr = THR_N;
    endcase
  end

  assign over = en & thr_mode & active & (err_cnt > thr);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      unl_now    <= 1'b0;
      stretch    <= '0;
      unlock_low <= 1'b0;
    end else begin
      if (!thr_mode)
        unl_now <= 1'b0;
      else if (over)
        unl_now <= 1'b1;
      else if (pulse_end)
        unl_now <= 1'b0;

      if (!thr_mode)
        stretch <= '0;
      else if (over)
        stretch <= STRETCH_LOAD;
      else if (ms_tick && (stretch != '0))
        stretch <= stretch - 1'b1;

      case (mode)
        UNL_OFF: unlock_low <= 1'b0;
        UNL_RAW: unlock_low <= active;
        default: unlock_low <= over | (stretch != '0);
      endcase
    end
  end

  always_comb begin
    case (mode)
      UNL_OFF: sub_unl = 1'b0;
      UNL_RAW: sub_unl = active;
      default: sub_unl = unl_now | over;
    endcase
  end

  // R5: monitor off never pulls the pin
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode == UNL_OFF) |=> !unlock_low);

  // R7: an over-threshold cycle is flagged on the next cycle
  a_r7_flag_on_over: assert property (@(posedge clk) disable iff (rst)
    (over && en) |=> unlock_low);

  // R8: every over-threshold cycle reloads the stretch
  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (over && en) |=> (stretch == STRETCH_LOAD));

  // R8: the stretch only shrinks on a tick
  a_r8_tick_only: assert property (@(posedge clk) disable iff (rst)
    (en && thr_mode && !over && !ms_tick) |=> $stable(stretch));
endmodule

// File: rtl/pfd_pump_drive.sv
module pfd_pump_drive
  import pfd_lock_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  force_low,
  input  logic                  lead_fb,
  input  logic                  lead_ref,
  input  logic [PUMP_COUNT-1:0] gate,
  output logic [PUMP_COUNT-1:0] drv_hi,
  output logic [PUMP_COUNT-1:0] drv_lo
);
  for (genvar p = 0; p < PUMP_COUNT; p++) begin : g_pump
    always_ff @(posedge clk) begin
      if (rst || !en) begin
        drv_hi[p] <= 1'b0;
        drv_lo[p] <= 1'b0;
      end else if (force_low) begin
        drv_hi[p] <= 1'b0;
        drv_lo[p] <= 1'b1;
      end else begin
        drv_hi[p] <= gate[p] & lead_fb;
        drv_lo[p] <= gate[p] & lead_ref;
      end
    end

    // R1: a pump never drives both ways
    a_r1_no_contention: assert property (@(posedge clk) disable iff (rst)
      $onehot0({drv_hi[p], drv_lo[p]}));
  end

  // R3: inhibit releases every pump
  a_r3_inhibit: assert property (@(posedge clk) disable iff (rst)
    !en |=> (drv_hi == '0) && (drv_lo == '0));

  // R4: force parks every pump low
  a_r4_force: assert property (@(posedge clk) disable iff (rst)
    (en && force_low) |=> (drv_lo == '1) && (drv_hi == '0));
endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
  import pfd_lock_pkg::*;
#(
  parameter int THR_NARROW    = 140,
  parameter int THR_WIDE      = 278,
  parameter int STRETCH_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pll_en,
  input  logic       ref_edge,
  input  logic       fb_edge,
  input  logic       ms_tick,
  input  logic [1:0] unl_sel,
  input  logic       sub_en,
  input  logic       sub_always,
  input  logic       force_low,
  output logic       pump_hi,
  output logic       pump_lo,
  output logic       aux_hi,
  output logic       aux_lo,
  output logic       unlock_low
);
  localparam int THR_MAX = (THR_WIDE > THR_NARROW) ? THR_WIDE : THR_NARROW;
  localparam int CNT_W   = $clog2(THR_MAX + 2);

  logic                  lead_fb, lead_ref, active, pulse_end;
  logic [CNT_W-1:0]      err_cnt;
  logic                  sub_unl;
  logic [PUMP_COUNT-1:0] gate, drv_hi, drv_lo;

  pfd_edge_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .en        (pll_en),
    .ref_edge  (ref_edge),
    .fb_edge   (fb_edge),
    .lead_fb   (lead_fb),
    .lead_ref  (lead_ref),
    .active    (active),
    .pulse_end (pulse_end),
    .err_cnt   (err_cnt)
  );

  pfd_unlock_mon #(
    .THR_NARROW    (THR_NARROW),
    .THR_WIDE      (THR_WIDE),
    .CNT_W         (CNT_W),
    .STRETCH_TICKS (STRETCH_TICKS)
  ) u_mon (
    .clk        (clk),
    .rst        (rst),
    .en         (pll_en),
    .sel        (unl_sel),
    .active     (active),
    .pulse_end  (pulse_end),
    .err_cnt    (err_cnt),
    .ms_tick    (ms_tick),
    .unlock_low (unlock_low),
    .sub_unl    (sub_unl)
  );

  assign gate[PUMP_MAIN] = 1'b1;
  assign gate[PUMP_AUX]  = sub_en & (sub_always | sub_unl);

  pfd_pump_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .en        (pll_en),
    .force_low (force_low),
    .lead_fb   (lead_fb),
    .lead_ref  (lead_ref),
    .gate      (gate),
    .drv_hi    (drv_hi),
    .drv_lo    (drv_lo)
  );

  assign pump_hi = drv_hi[PUMP_MAIN];
  assign pump_lo = drv_lo[PUMP_MAIN];
  assign aux_hi  = drv_hi[PUMP_AUX];
  assign aux_lo  = drv_lo[PUMP_AUX];

  // R9: auxiliary pump disabled stays quiet
  a_r9_aux_off: assert property (@(posedge clk) disable iff (rst)
    (!sub_en && !force_low) |=> !(aux_hi || aux_lo));

  // R10: continuous auxiliary pump mirrors the main pump
  a_r10_mirror: assert property (@(posedge clk) disable iff (rst)
    (sub_en && sub_always) |=> (aux_hi == pump_hi) && (aux_lo == pump_lo));
endmodule

// File: tb/sim_pfd_lock_monitor.sv
`timescale 1ns/1ps
module sim_pfd_lock_monitor;
  localparam int TN = 3;
  localparam int TW = 6;
  localparam int ST = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pll_en = 1'b0, ref_edge = 1'b0, fb_edge = 1'b0, ms_tick = 1'b0;
  logic [1:0] unl_sel = 2'b00;
  logic sub_en = 1'b0, sub_always = 1'b0, force_low = 1'b0;
  logic pump_hi, pump_lo, aux_hi, aux_lo, unlock_low;

  int checks = 0;
  int errors = 0;
  int c_mh, c_ml, c_sh, c_sl, c_ul;

  always #2 clk = ~clk;

  pfd_lock_monitor #(.THR_NARROW(TN), .THR_WIDE(TW), .STRETCH_TICKS(ST)) u0 (
    .clk(clk), .rst(rst), .pll_en(pll_en), .ref_edge(ref_edge), .fb_edge(fb_edge),
    .ms_tick(ms_tick), .unl_sel(unl_sel), .sub_en(sub_en), .sub_always(sub_always),
    .force_low(force_low), .pump_hi(pump_hi), .pump_lo(pump_lo), .aux_hi(aux_hi),
    .aux_lo(aux_lo), .unlock_low(unlock_low)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
  endtask

  // one error pulse of w cycles; counts output cycles over the window
  task automatic pulse_pair(input bit fb_first, input int w);
    c_mh = 0; c_ml = 0; c_sh = 0; c_sl = 0; c_ul = 0;
    for (int i = 0; i < w + 7; i++) begin
      @(negedge clk);
      c_mh += int'(pump_hi); c_ml += int'(pump_lo);
      c_sh += int'(aux_hi);  c_sl += int'(aux_lo);
      c_ul += int'(unlock_low);
      fb_edge  = (fb_first && i == 0) || (!fb_first && i == w);
      ref_edge = (!fb_first && i == 0) || (fb_first && i == w);
    end
    @(negedge clk);
    fb_edge = 1'b0; ref_edge = 1'b0;
  endtask

  task automatic settle();
    pulse_pair(1'b1, 1);
    tick(); tick(); tick();
    idle(2);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1: reset state
    chk("R1 reset pump_hi", pump_hi, 0);
    chk("R1 reset pump_lo", pump_lo, 0);
    chk("R1 reset aux", aux_hi | aux_lo, 0);
    chk("R1 reset unlock", unlock_low, 0);
    rst = 1'b0; pll_en = 1'b1;
    idle(2);

    // R2, R6, R10: raw monitor, continuous aux
    unl_sel = 2'b01; sub_en = 1'b1; sub_always = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < 10; w++) begin
        pulse_pair(d == 0, w);
        chk("R2 main hi", c_mh, (d == 0) ? w : 0);
        chk("R2 main lo", c_ml, (d == 1) ? w : 0);
        chk("R6 raw unlock", c_ul, w);
        chk("R10 aux hi", c_sh, (d == 0) ? w : 0);
        chk("R10 aux lo", c_sl, (d == 1) ? w : 0);
      end
    end

    // R7, R11: narrow threshold, aux only while unlocked
    unl_sel = 2'b10; sub_always = 1'b0;
    for (int d = 0; d < 2; d++) begin
      for (int w = 0; w < 10; w++) begin
        settle();
        pulse_pair(d == 0, w);
        chk("R7 narrow flag", int'(c_ul > 0), int'(w > TN));
        chk("R11 aux from over", (d == 0) ? c_sh : c_sl, (w > TN) ? w - TN : 0);
        chk("R11 aux other side", (d == 0) ? c_sl : c_sh, 0);
        chk("R2 main width", (d == 0) ? c_mh : c_ml, w);
      end
    end

    // R7: wide threshold
    unl_sel = 2'b11;
    for (int w = 0; w < 10; w++) begin
      settle();
      pulse_pair(1'b0, w);
      chk("R7 wide flag", int'(c_ul > 0), int'(w > TW));
    end

    // R8: stretch held until ST ticks
    unl_sel = 2'b10;
    settle();
    pulse_pair(1'b1, 6);
    chk("R8 held after pulse", unlock_low, 1);
    tick(); idle(2);
    chk("R8 held after one tick", unlock_low, 1);
    tick(); idle(2);
    chk("R8 released after last tick", unlock_low, 0);

    // R11: aux keeps running through one in-threshold pulse
    settle();
    pulse_pair(1'b1, 5);
    chk("R11 first over pulse", c_sh, 5 - TN);
    pulse_pair(1'b1, 1);
    chk("R11 runs on next in-threshold pulse", c_sh, 1);
    pulse_pair(1'b1, 1);
    chk("R11 idle after locked pulse", c_sh, 0);

    // R5: monitor off
    unl_sel = 2'b00;
    idle(2);
    pulse_pair(1'b1, 8);
    chk("R5 off no unlock", c_ul, 0);

    // R9: aux disabled
    unl_sel = 2'b10; sub_en = 1'b0; sub_always = 1'b1;
    settle();
    pulse_pair(1'b1, 8);
    chk("R9 aux off", c_sh + c_sl, 0);
    chk("R9 main still runs", c_mh, 8);

    // R4: force low
    force_low = 1'b1;
    idle(2);
    chk("R4 main lo", pump_lo, 1);
    chk("R4 aux lo", aux_lo, 1);
    chk("R4 highs off", pump_hi | aux_hi, 0);
    pulse_pair(1'b1, 4);
    chk("R4 no high during force", c_mh + c_sh, 0);

    // R3: inhibit wins over force
    pll_en = 1'b0;
    idle(2);
    chk("R3 all pumps off", pump_hi | pump_lo | aux_hi | aux_lo, 0);
    chk("R3 unlock released", unlock_low, 0);
    pulse_pair(1'b1, 4);
    chk("R3 no drive while inhibited", c_mh + c_ml + c_sh + c_sl + c_ul, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule